// File: doc/BRIEF.md
# Privileged Accelerator Configuration Bank

This block holds the three configuration registers that govern a bytecode execution accelerator inside a processor core. Software reaches them through a coprocessor-style port: a one-cycle strobe carries a register index, a read/write flag, a privilege flag and write data. The read result and an access-fault indication come back one clock later. Each register applies its own rule per privilege level. The identity register is read-only everywhere. The OS control register is reserved to privileged code, and any user access to it faults. The main configuration register may be written from user mode but reads back as zero there, while privileged code has full read/write access.

Two bits leave the bank towards the mode-entry logic: an enable bit held in the main configuration register and a configuration-valid bit held in the OS control register. A small steering stage is built in. A branch-to-bytecode request is granted to the accelerator only when both bits are set, and otherwise it falls back to a plain branch. A build parameter selects a minimal variant in which every register reads as zero, nothing faults and the accelerator is never entered.

Top module: `acfg_bank`

## Requirements
- R1: After reset the OS control and main configuration registers hold 0, `cp_rdata` is 0, `cp_fault` is 0, and both `cfg_en` and `cfg_valid` are 0.
- R2: A read of index 0 returns the `ID_VAL` parameter (default 32'h4A10_0C01) at either privilege level without a fault. A write to index 0 is ignored and does not fault.
- R3: Any access to index 1 with `cp_priv` = 0 raises `cp_fault` in the following cycle, returns 0 on `cp_rdata` and leaves every register unchanged.
- R4: With `cp_priv` = 1, index 1 reads and writes. Only the bits in `OS_WMASK` (default bits 1:0) are stored, and bit 1 of this register drives `cfg_valid`.
- R5: With `cp_priv` = 0, a write to index 2 stores `cp_wdata` under `MAIN_WMASK` (default bits 3:0). A read of index 2 returns 0 and does not fault.
- R6: With `cp_priv` = 1, index 2 reads and writes under `MAIN_WMASK`, and bit 0 of this register drives `cfg_en`.
- R7: Any access to an index above 2 returns 0, does not fault and changes no register.
- R8: While `br_req` is 1, exactly one of `br_accel` and `br_plain` is 1. `br_accel` is 1 only if `cfg_en` and `cfg_valid` are both 1. While `br_req` is 0, both outputs are 0.
- R9: A register write takes effect at the clock edge that ends its strobe. A branch request in the strobe cycle is steered by the old values, and from the next cycle the new values steer.
- R10: With `LITE` = 1, every read returns 0, no access faults, `cfg_en` and `cfg_valid` stay 0, and every branch request leaves on `br_plain`.
- R11: `cp_rdata` and `cp_fault` are registered. They present the result of a strobe in the next cycle only, and are 0 in a cycle that follows no strobe, so each faulting access produces a one-cycle fault pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cp_stb | input | 1 | Access strobe, one cycle per access |
| cp_wr | input | 1 | 1 = write, 0 = read |
| cp_idx | input | IDX_W | Register index (0 identity, 1 OS control, 2 main configuration) |
| cp_priv | input | 1 | 1 = privileged, 0 = user |
| cp_wdata | input | DW | Write data |
| cp_rdata | output | DW | Read data, valid the cycle after a read strobe |
| cp_fault | output | 1 | Access-fault pulse, the cycle after a faulting strobe |
| br_req | input | 1 | Branch-to-bytecode request |
| br_accel | output | 1 | Request granted to the accelerator |
| br_plain | output | 1 | Request falls back to a plain branch |
| cfg_en | output | 1 | Enable bit (main configuration bit 0) |
| cfg_valid | output | 1 | Configuration-valid bit (OS control bit 1) |

## Verification
The case of interest is a configuration write that arrives in the same cycle as a branch-to-bytecode request. The bench raises `br_req` together with the write strobe, first with the enable and valid bits set and then while clearing them. It expects the steering decided in that cycle to follow the old register contents, and the steering in the next cycle to follow the new ones. The random phase pairs random branch requests with random accesses at both privilege levels and across in-range and out-of-range indices, and it compares every result against a model that the bench keeps.

// File: rtl/acfg_pkg.sv
package acfg_pkg;

   // register indices: the decode relies on these values
   localparam int unsigned IX_IDENT = 0;
   localparam int unsigned IX_OSCTL = 1;
   localparam int unsigned IX_MAIN  = 2;

   // bit positions that feed the mode-entry logic
   localparam int unsigned EN_BIT = 0;
   localparam int unsigned CV_BIT = 1;

   typedef enum logic [1:0] {
      RSEL_ZERO  = 2'd0,
      RSEL_IDENT = 2'd1,
      RSEL_OSCTL = 2'd2,
      RSEL_MAIN  = 2'd3
   } rsel_e;

   typedef struct packed {
      logic  wr_os;
      logic  wr_main;
      logic  fault;
      logic  rd_en;
      rsel_e rsel;
   } acc_dec_t;

endpackage

// File: rtl/acfg_decode.sv
module acfg_decode
   import acfg_pkg::*;
#(
   parameter int unsigned IDX_W = 4,
   parameter bit          LITE  = 1'b0
) (
   input  logic             stb,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic             priv,
   output acc_dec_t         dec
);

   localparam logic [IDX_W-1:0] K_IDENT = IDX_W'(IX_IDENT);
   localparam logic [IDX_W-1:0] K_OSCTL = IDX_W'(IX_OSCTL);
   localparam logic [IDX_W-1:0] K_MAIN  = IDX_W'(IX_MAIN);

   generate
      if (LITE) begin : g_lite
         logic unused_dec;
         assign unused_dec = ^{stb, wr, idx, priv};
         assign dec = '0;
      end else begin : g_full
         always_comb begin
            dec      = '0;
            dec.rsel = RSEL_ZERO;
            if (stb) begin
               unique case (idx)
                  K_IDENT: begin
                     if (!wr) begin
                        dec.rd_en = 1'b1;
                        dec.rsel  = RSEL_IDENT;
                     end
                  end
                  K_OSCTL: begin
                     if (!priv) begin
                        dec.fault = 1'b1;
                     end else if (wr) begin
                        dec.wr_os = 1'b1;
                     end else begin
                        dec.rd_en = 1'b1;
                        dec.rsel  = RSEL_OSCTL;
                     end
                  end
                  K_MAIN: begin
                     if (wr) begin
                        dec.wr_main = 1'b1;
                     end else if (priv) begin
                        dec.rd_en = 1'b1;
                        dec.rsel  = RSEL_MAIN;
                     end
                  end
                  default: begin
                     dec.rsel = RSEL_ZERO;
                  end
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/acfg_regs.sv
module acfg_regs
   import acfg_pkg::*;
#(
   parameter int unsigned   DW         = 32,
   parameter logic [DW-1:0] ID_VAL     = 32'h4A10_0C01,
   parameter logic [DW-1:0] OS_WMASK   = 32'h0000_0003,
   parameter logic [DW-1:0] MAIN_WMASK = 32'h0000_000F,
   parameter bit            LITE       = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  acc_dec_t      dec,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          fault,
   output logic          cfg_en,
   output logic          cfg_valid
);

   generate
      if (LITE) begin : g_lite
         logic unused_regs;
         assign unused_regs = ^{clk, rst_n, dec, wdata};
         assign rdata     = '0;
         assign fault     = 1'b0;
         assign cfg_en    = 1'b0;
         assign cfg_valid = 1'b0;
      end else begin : g_full
         logic [DW-1:0] os_q;
         logic [DW-1:0] main_q;
         logic [DW-1:0] rd_mux;
         logic [DW-1:0] rdata_q;
         logic          fault_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               os_q <= '0;
            end else if (dec.wr_os) begin
               os_q <= wdata & OS_WMASK;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               main_q <= '0;
            end else if (dec.wr_main) begin
               main_q <= wdata & MAIN_WMASK;
            end
         end

         always_comb begin
            unique case (dec.rsel)
               RSEL_IDENT: rd_mux = ID_VAL;
               RSEL_OSCTL: rd_mux = os_q;
               RSEL_MAIN:  rd_mux = main_q;
               default:    rd_mux = '0;
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata_q <= '0;
               fault_q <= 1'b0;
            end else begin
               rdata_q <= dec.rd_en ? rd_mux : '0;
               fault_q <= dec.fault;
            end
         end

         assign rdata     = rdata_q;
         assign fault     = fault_q;
         assign cfg_en    = main_q[EN_BIT];
         assign cfg_valid = os_q[CV_BIT];
      end
   endgenerate

endmodule

// File: rtl/acfg_entry.sv
module acfg_entry #(
   parameter bit LITE = 1'b0
) (
   input  logic br_req,
   input  logic cfg_en,
   input  logic cfg_valid,
   output logic br_accel,
   output logic br_plain
);

   logic grant;

   generate
      if (LITE) begin : g_lite
         logic unused_entry;
         assign unused_entry = cfg_en ^ cfg_valid;
         assign grant = 1'b0;
      end else begin : g_full
         assign grant = cfg_en & cfg_valid;
      end
   endgenerate

   assign br_accel = br_req & grant;
   assign br_plain = br_req & ~grant;

endmodule

// File: rtl/acfg_bank.sv
module acfg_bank
   import acfg_pkg::*;
#(
   parameter int unsigned   DW         = 32,
   parameter int unsigned   IDX_W      = 4,
   parameter logic [DW-1:0] ID_VAL     = 32'h4A10_0C01,
   parameter logic [DW-1:0] OS_WMASK   = 32'h0000_0003,
   parameter logic [DW-1:0] MAIN_WMASK = 32'h0000_000F,
   parameter bit            LITE       = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cp_stb,
   input  logic             cp_wr,
   input  logic [IDX_W-1:0] cp_idx,
   input  logic             cp_priv,
   input  logic [DW-1:0]    cp_wdata,
   output logic [DW-1:0]    cp_rdata,
   output logic             cp_fault,
   input  logic             br_req,
   output logic             br_accel,
   output logic             br_plain,
   output logic             cfg_en,
   output logic             cfg_valid
);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("acfg_bank: DW must be at least 2");
      end
      if (IDX_W < 2) begin : g_bad_idx
         $error("acfg_bank: IDX_W must hold index 2");
      end
      if (OS_WMASK[CV_BIT] == 1'b0) begin : g_bad_osmask
         $error("acfg_bank: OS_WMASK must keep the valid bit writable");
      end
      if (MAIN_WMASK[EN_BIT] == 1'b0) begin : g_bad_mainmask
         $error("acfg_bank: MAIN_WMASK must keep the enable bit writable");
      end
   endgenerate

   acc_dec_t dec;

   acfg_decode #(
      .IDX_W (IDX_W),
      .LITE  (LITE)
   ) u_dec (
      .stb  (cp_stb),
      .wr   (cp_wr),
      .idx  (cp_idx),
      .priv (cp_priv),
      .dec  (dec)
   );

   acfg_regs #(
      .DW         (DW),
      .ID_VAL     (ID_VAL),
      .OS_WMASK   (OS_WMASK),
      .MAIN_WMASK (MAIN_WMASK),
      .LITE       (LITE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec       (dec),
      .wdata     (cp_wdata),
      .rdata     (cp_rdata),
      .fault     (cp_fault),
      .cfg_en    (cfg_en),
      .cfg_valid (cfg_valid)
   );

   acfg_entry #(
      .LITE (LITE)
   ) u_entry (
      .br_req    (br_req),
      .cfg_en    (cfg_en),
      .cfg_valid (cfg_valid),
      .br_accel  (br_accel),
      .br_plain  (br_plain)
   );

endmodule

// File: rtl/acfg_bank_chk.sv
module acfg_bank_chk #(
   parameter int unsigned   DW     = 32,
   parameter int unsigned   IDX_W  = 4,
   parameter logic [DW-1:0] ID_VAL = 32'h4A10_0C01,
   parameter bit            LITE   = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cp_stb,
   input logic             cp_wr,
   input logic [IDX_W-1:0] cp_idx,
   input logic             cp_priv,
   input logic [DW-1:0]    cp_rdata,
   input logic             cp_fault,
   input logic             br_req,
   input logic             br_accel,
   input logic             br_plain,
   input logic             cfg_en,
   input logic             cfg_valid
);

   localparam logic [IDX_W-1:0] K_ID   = IDX_W'(0);
   localparam logic [IDX_W-1:0] K_OS   = IDX_W'(1);
   localparam logic [IDX_W-1:0] K_MAIN = IDX_W'(2);

   AST_BR_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      br_req |-> $countones({br_accel, br_plain}) == 1); // R8
   AST_BR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !br_req |-> !br_accel && !br_plain); // R8
   AST_ACCEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      br_accel |-> cfg_en && cfg_valid); // R8
   AST_CFG_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !cp_stb |=> $stable(cfg_en) && $stable(cfg_valid)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cp_stb |=> cp_rdata == '0 && !cp_fault); // R11
   AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_stb && cp_idx > K_MAIN) |=> cp_rdata == '0 && !cp_fault
         && $stable(cfg_en) && $stable(cfg_valid)); // R7
   AST_USER_MAIN_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_stb && !cp_wr && !cp_priv && cp_idx == K_MAIN)
         |=> cp_rdata == '0 && !cp_fault); // R5

   generate
      if (LITE) begin : g_lite
         AST_LITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !cp_fault && cp_rdata == '0 && !br_accel && !cfg_en && !cfg_valid); // R10
      end else begin : g_full
         AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            cp_fault |-> $past(cp_stb && !cp_priv && cp_idx == K_OS)); // R3
         AST_USER_OS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
            (cp_stb && !cp_priv && cp_idx == K_OS)
               |=> cp_fault && cp_rdata == '0 && $stable(cfg_valid)
                  && $stable(cfg_en)); // R3
         AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (cp_stb && !cp_wr && cp_idx == K_ID)
               |=> cp_rdata == ID_VAL && !cp_fault); // R2
      end
   endgenerate

endmodule

bind acfg_bank acfg_bank_chk #(
   .DW     (DW),
   .IDX_W  (IDX_W),
   .ID_VAL (ID_VAL),
   .LITE   (LITE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cp_stb    (cp_stb),
   .cp_wr     (cp_wr),
   .cp_idx    (cp_idx),
   .cp_priv   (cp_priv),
   .cp_rdata  (cp_rdata),
   .cp_fault  (cp_fault),
   .br_req    (br_req),
   .br_accel  (br_accel),
   .br_plain  (br_plain),
   .cfg_en    (cfg_en),
   .cfg_valid (cfg_valid)
);

// File: tb/sim_acfg_bank.sv
module sim_acfg_bank;

   localparam logic [31:0] ID_V   = 32'h4A10_0C01;
   localparam logic [31:0] OS_M   = 32'h0000_0003;
   localparam logic [31:0] MAIN_M = 32'h0000_000F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cp_stb = 1'b0;
   logic        cp_wr = 1'b0;
   logic [3:0]  cp_idx = '0;
   logic        cp_priv = 1'b0;
   logic [31:0] cp_wdata = '0;
   logic        br_req = 1'b0;

   logic [31:0] rd0, rd1;
   logic        flt0, flt1, acc0, acc1, pln0, pln1, en0, en1, cv0, cv1;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_os = '0;
   logic [31:0] m_main = '0;

   always #2 clk = ~clk;

   acfg_bank u0 (
      .clk(clk), .rst_n(rst_n), .cp_stb(cp_stb), .cp_wr(cp_wr), .cp_idx(cp_idx),
      .cp_priv(cp_priv), .cp_wdata(cp_wdata), .cp_rdata(rd0), .cp_fault(flt0),
      .br_req(br_req), .br_accel(acc0), .br_plain(pln0), .cfg_en(en0), .cfg_valid(cv0)
   );

   acfg_bank #(.LITE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .cp_stb(cp_stb), .cp_wr(cp_wr), .cp_idx(cp_idx),
      .cp_priv(cp_priv), .cp_wdata(cp_wdata), .cp_rdata(rd1), .cp_fault(flt1),
      .br_req(br_req), .br_accel(acc1), .br_plain(pln1), .cfg_en(en1), .cfg_valid(cv1)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // {fault, rdata} expected one cycle after the strobe
   function automatic logic [32:0] f_expect(logic wr, logic [3:0] idx, logic priv);
      if (idx == 4'd0) return wr ? 33'd0 : {1'b0, ID_V};
      if (idx == 4'd1) begin
         if (!priv) return {1'b1, 32'd0};
         return wr ? 33'd0 : {1'b0, m_os};
      end
      if (idx == 4'd2) return (wr || !priv) ? 33'd0 : {1'b0, m_main};
      return 33'd0;
   endfunction

   function automatic string f_tag(logic [3:0] idx, logic priv);
      if (idx == 4'd0) return "R2";
      if (idx == 4'd1) return priv ? "R4" : "R3";
      if (idx == 4'd2) return priv ? "R6" : "R5";
      return "R7";
   endfunction

   task automatic do_acc(logic wr, logic [3:0] idx, logic priv, logic [31:0] wd, logic br);
      logic [32:0] exp;
      logic        old_go, new_go;
      string       tg;
      tg = f_tag(idx, priv);
      @(negedge clk);
      cp_stb = 1'b1; cp_wr = wr; cp_idx = idx; cp_priv = priv; cp_wdata = wd; br_req = br;
      #1;
      old_go = m_main[0] & m_os[1];
      check("R9 same-cycle accel", {31'd0, acc0}, {31'd0, br & old_go});
      check("R9 same-cycle plain", {31'd0, pln0}, {31'd0, br & ~old_go});
      check("R10 lite plain", {30'd0, acc1, pln1}, {30'd0, 1'b0, br});
      exp = f_expect(wr, idx, priv);
      if (wr && idx == 4'd1 && priv) m_os = wd & OS_M;
      if (wr && idx == 4'd2) m_main = wd & MAIN_M;
      @(negedge clk);
      cp_stb = 1'b0;
      check({tg, " rdata"}, rd0, exp[31:0]);
      check({tg, " fault"}, {31'd0, flt0}, {31'd0, exp[32]});
      check("R6 cfg_en", {31'd0, en0}, {31'd0, m_main[0]});
      check("R4 cfg_valid", {31'd0, cv0}, {31'd0, m_os[1]});
      check("R10 lite rdata", rd1, 32'd0);
      check("R10 lite fault/cfg", {29'd0, flt1, en1, cv1}, 32'd0);
      new_go = m_main[0] & m_os[1];
      check("R9 next-cycle accel", {31'd0, acc0}, {31'd0, br & new_go});
      br_req = 1'b0;
      if (exp[32]) begin
         @(negedge clk);
         check("R11 fault pulse ends", {31'd0, flt0}, 32'd0);
         check("R11 idle rdata", rd0, 32'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rdata", rd0, 32'd0);
      check("R1 fault", {31'd0, flt0}, 32'd0);
      check("R1 cfg", {30'd0, en0, cv0}, 32'd0);
      br_req = 1'b1; #1;
      check("R1 branch plain", {30'd0, acc0, pln0}, 32'd1);
      br_req = 1'b0;
      do_acc(1'b0, 4'd1, 1'b1, 32'd0, 1'b0);
      do_acc(1'b0, 4'd2, 1'b1, 32'd0, 1'b0);
      // enable path
      do_acc(1'b1, 4'd2, 1'b1, 32'hFFFF_FFFF, 1'b1);
      do_acc(1'b1, 4'd1, 1'b1, 32'hFFFF_FFFF, 1'b1);
      do_acc(1'b0, 4'd1, 1'b1, 32'd0, 1'b1);
      // user faults on OS control
      do_acc(1'b0, 4'd1, 1'b0, 32'd0, 1'b1);
      do_acc(1'b1, 4'd1, 1'b0, 32'd0, 1'b1);
      // user main: read hidden, write clears enable in branch cycle
      do_acc(1'b0, 4'd2, 1'b0, 32'd0, 1'b1);
      do_acc(1'b1, 4'd2, 1'b0, 32'h0000_0006, 1'b1);
      do_acc(1'b0, 4'd2, 1'b1, 32'd0, 1'b0);
      do_acc(1'b1, 4'd2, 1'b0, 32'h0000_0009, 1'b1);
      // identity: write ignored, readable at both levels
      do_acc(1'b1, 4'd0, 1'b1, 32'h1234_5678, 1'b0);
      do_acc(1'b0, 4'd0, 1'b1, 32'd0, 1'b0);
      do_acc(1'b0, 4'd0, 1'b0, 32'd0, 1'b0);
      // out of range
      do_acc(1'b1, 4'd3, 1'b1, 32'd0, 1'b1);
      do_acc(1'b1, 4'd15, 1'b0, 32'd0, 1'b1);
      do_acc(1'b0, 4'd7, 1'b1, 32'd0, 1'b0);
      do_acc(1'b0, 4'd2, 1'b1, 32'd0, 1'b0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [3:0] ix;
         ix = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 3);
         do_acc(1'($urandom), ix, 1'($urandom), $urandom, 1'($urandom));
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule